// File: doc/BRIEF.md
# Multi-Identifier Codeword Matcher

This block sits behind the codeword framer of a paging receiver. For every 32-bit codeword it is handed, it decides whether the word belongs to one of six programmable identifiers or to the fixed standard synchronization word. It answers with a single-cycle strobe and an identifier number from 1 to 7. Each slot is configured through a byte-wide write port. A slot can act in one of two ways: as an address identifier, which is compared exactly against the 18 address bits of an address codeword, or as a user sync word, which is compared against the upper 24 bits of the codeword with a tolerance of two bit errors. Only slots 3 to 6 can take the sync-word role.

A user sync word that lies too close to the alternating preamble would make preamble look like sync. Such a slot is flagged on a per-slot configuration-error output as soon as it is written, and it is removed from matching. The standard sync word `0x7CD215D8` is always active, reports as identifier 7, and also accepts up to two bit errors. When several identifiers match the same codeword, the lowest identifier number is reported.

Top module: `cwm_matcher`

## Requirements
- R1: Slot k (k = 1..6) stores the word W = {byte1, byte2, byte3}, with byte1 as the most significant byte. Byte1 is written at offset 0x0F+k, byte2 at 0x17+k and byte3 at 0x1F+k. Bit k-1 of offset 0x26 enables slot k. Bit k-1 of offset 0x27 selects the sync-word role for slot k (1 = sync word). Writes to any other offset change nothing.
- R2: An enabled address slot matches a codeword whose bit 31 is 0 and whose bits 30..13 equal W[17:0]. On the clock edge after the codeword is presented with `cw_valid`, `match_valid` rises and `match_id` holds the slot number.
- R3: A codeword with bit 31 set never matches an address slot.
- R4: Slots 1 and 2 always behave as address slots, whatever their role bit says, and their configuration-error bits are always 0.
- R5: An enabled, error-free sync-word slot (3..6) matches when codeword bits 31..8 differ from W in at most 2 positions. With 3 differences it does not match.
- R6: A codeword within Hamming distance 2 of 0x7CD215D8 matches identifier 7, even when every slot is disabled. At distance 3 it does not match.
- R7: `cfg_err[k-1]` is 1 exactly when slot k is in the sync-word role and W differs from 0xAAAAAA in 6 or fewer bit positions (so 6 sets the flag and 7 clears it). A flagged slot never matches.
- R8: When several identifiers match the same codeword, the lowest identifier number is reported.
- R9: `match_valid` is high for exactly one cycle per presented codeword that matches, and is never high otherwise. Whenever `match_valid` is low, `match_id` is 0.
- R10: A disabled slot never matches.
- R11: During and after reset, `match_valid`, `match_id` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 6 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| cw_valid | input | 1 | Codeword present this cycle |
| cw | input | 32 | Received codeword, bit 31 first on air |
| match_valid | output | 1 | One-cycle match strobe |
| match_id | output | 3 | Matched identifier 1..7, 0 when no match |
| cfg_err | output | 6 | Per-slot user sync word too close to preamble |

## Verification
The hardest case to reach is a flagged sync-word slot that would have won the priority contest if it had been allowed to match. To show that it is truly excluded, the word must land on a higher-numbered slot instead of on nothing. The stimulus programs slot 4 at preamble distance 6 and slot 5 one bit away from it at distance 7. A codeword equal to slot 4's word must then report 5. Rewriting a single byte of slot 5 then pushes it across the distance boundary, and the bench checks that its error flag follows.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  localparam int CW_W        = 32;
  localparam int NUM_SLOTS   = 6;
  localparam int SLOT_BYTES  = 3;
  localparam int SLOT_W      = SLOT_BYTES * 8;
  localparam int ADDR_BITS   = 18;
  localparam int CFG_AW      = 6;
  localparam int ID_W        = 3;
  localparam int NUM_IDS     = NUM_SLOTS + 1;
  localparam int FIRST_SYNC  = 2;          // zero-based index of slot 3
  localparam int ROW_BASE    = 'h10;
  localparam int ROW_STRIDE  = 'h08;
  localparam int EN_OFFS     = 'h26;
  localparam int ROLE_OFFS   = 'h27;
  localparam int SYNC_TOL    = 2;
  localparam int PRE_MAX_BAD = 6;
  localparam logic [CW_W-1:0]   STD_SYNC = 32'h7CD2_15D8;
  localparam logic [SLOT_W-1:0] PREAMBLE = 24'hAAAAAA;

  function automatic logic [5:0] ones32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/cwm_cfg_regs.sv
module cwm_cfg_regs
  import cwm_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [CFG_AW-1:0]                    cfg_addr,
  input  logic [7:0]                           cfg_wdata,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]     slot_word,
  output logic [NUM_SLOTS-1:0]                 slot_en,
  output logic [NUM_SLOTS-1:0]                 slot_role
);
  logic [NUM_SLOTS-1:0][SLOT_BYTES-1:0][7:0] byte_q, byte_d;
  logic [NUM_SLOTS-1:0] en_q, en_d, role_q, role_d;

  always_comb begin
    byte_d = byte_q;
    en_d   = en_q;
    role_d = role_q;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      for (int j = 0; j < SLOT_BYTES; j++) begin
        if (cfg_addr == CFG_AW'(ROW_BASE + j * ROW_STRIDE + k))
          byte_d[k][SLOT_BYTES-1-j] = cfg_wdata;
      end
    end
    if (cfg_addr == CFG_AW'(EN_OFFS))   en_d   = cfg_wdata[NUM_SLOTS-1:0];
    if (cfg_addr == CFG_AW'(ROLE_OFFS)) role_d = cfg_wdata[NUM_SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      en_q   <= '0;
      role_q <= '0;
    end else if (cfg_we) begin
      byte_q <= byte_d;
      en_q   <= en_d;
      role_q <= role_d;
    end
  end

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_word
      assign slot_word[k] = byte_q[k];
    end
  endgenerate
  assign slot_en   = en_q;
  assign slot_role = role_q;
endmodule

// File: rtl/cwm_slot_cmp.sv
module cwm_slot_cmp
  import cwm_pkg::*;
#(
  parameter bit CAN_SYNC = 1'b1
) (
  input  logic [CW_W-1:0]   cw,
  input  logic [SLOT_W-1:0] word,
  input  logic              en,
  input  logic              role,
  output logic              hit,
  output logic              cfg_err
);
  localparam int SYNC_LSB = CW_W - SLOT_W;

  logic       role_eff;
  logic       addr_hit;
  logic       sync_hit;
  logic [5:0] cw_dist;
  logic [5:0] pre_dist;

  generate
    if (CAN_SYNC) begin : g_sync
      assign role_eff = role;
    end else begin : g_addr_only
      assign role_eff = 1'b0;
    end
  endgenerate

  always_comb begin
    addr_hit = !cw[CW_W-1] && (cw[CW_W-2 -: ADDR_BITS] == word[ADDR_BITS-1:0]);
    cw_dist  = ones32({{SYNC_LSB{1'b0}}, cw[CW_W-1:SYNC_LSB] ^ word});
    pre_dist = ones32({{SYNC_LSB{1'b0}}, word ^ PREAMBLE});
    sync_hit = (cw_dist <= 6'(SYNC_TOL));
    cfg_err  = role_eff && (pre_dist <= 6'(PRE_MAX_BAD));
    hit      = en && (role_eff ? (sync_hit && !cfg_err) : addr_hit);
  end
endmodule

// File: rtl/cwm_prio.sv
module cwm_prio
  import cwm_pkg::*;
(
  input  logic [NUM_IDS-1:0] hits,
  output logic               any,
  output logic [ID_W-1:0]    id
);
  always_comb begin
    any = |hits;
    id  = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (hits[i]) id = ID_W'(i + 1);
    end
  end
endmodule

// File: rtl/cwm_matcher.sv
module cwm_matcher
  import cwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [7:0]           cfg_wdata,
  input  logic                 cw_valid,
  input  logic [CW_W-1:0]      cw,
  output logic                 match_valid,
  output logic [ID_W-1:0]      match_id,
  output logic [NUM_SLOTS-1:0] cfg_err
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_word;
  logic [NUM_SLOTS-1:0]             slot_en, slot_role;
  logic [NUM_IDS-1:0]               hits;
  logic                             any_hit;
  logic [ID_W-1:0]                  win_id;
  logic                             mv_d, mv_q;
  logic [ID_W-1:0]                  id_d, id_q;

  cwm_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .slot_word (slot_word),
    .slot_en   (slot_en),
    .slot_role (slot_role)
  );

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      cwm_slot_cmp #(.CAN_SYNC(k >= FIRST_SYNC)) u_cmp (
        .cw      (cw),
        .word    (slot_word[k]),
        .en      (slot_en[k]),
        .role    (slot_role[k]),
        .hit     (hits[k]),
        .cfg_err (cfg_err[k])
      );
    end
  endgenerate

  assign hits[NUM_IDS-1] = (ones32(cw ^ STD_SYNC) <= 6'(SYNC_TOL));

  cwm_prio u_prio (
    .hits (hits),
    .any  (any_hit),
    .id   (win_id)
  );

  always_comb begin
    mv_d = cw_valid && any_hit;
    id_d = mv_d ? win_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q <= 1'b0;
      id_q <= '0;
    end else begin
      mv_q <= mv_d;
      id_q <= id_d;
    end
  end

  assign match_valid = mv_q;
  assign match_id    = id_q;
endmodule

// File: rtl/cwm_matcher_chk.sv
module cwm_matcher_chk
  import cwm_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cw_valid,
  input logic [CW_W-1:0]      cw,
  input logic                 match_valid,
  input logic [ID_W-1:0]      match_id,
  input logic [NUM_SLOTS-1:0] cfg_err
);
  p_strobe_needs_cw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(cw_valid));
  p_idle_id_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> match_id == '0);
  p_id_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> match_id != '0);
  p_low_slots_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err[1:0] == 2'b00);
  p_std_sync_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw == STD_SYNC) |=> match_valid);
endmodule

bind cwm_matcher cwm_matcher_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cw_valid    (cw_valid),
  .cw          (cw),
  .match_valid (match_valid),
  .match_id    (match_id),
  .cfg_err     (cfg_err)
);

// File: tb/cwm_matcher_tb.sv
module cwm_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cw_valid = 1'b0;
  logic [31:0] cw = '0;
  logic        match_valid;
  logic [2:0]  match_id;
  logic [5:0]  cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [23:0] m_word [6];
  logic [5:0]  m_en = '0;
  logic [5:0]  m_role = '0;
  int          exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cwm_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cw_valid(cw_valid), .cw(cw),
    .match_valid(match_valid), .match_id(match_id), .cfg_err(cfg_err)
  );

  function automatic bit model_err(int k);
    return (k >= 2) && m_role[k] && ($countones(m_word[k] ^ 24'hAAAAAA) <= 6);
  endfunction

  function automatic int model_id(logic [31:0] c);
    for (int k = 0; k < 6; k++) begin
      if (m_en[k]) begin
        if (k >= 2 && m_role[k]) begin
          if (!model_err(k) && $countones(c[31:8] ^ m_word[k]) <= 2) return k + 1;
        end else if (!c[31] && c[30:13] == m_word[k][17:0]) return k + 1;
      end
    end
    if ($countones(c ^ 32'h7CD215D8) <= 2) return 7;
    return 0;
  endfunction

  function automatic logic [5:0] model_errs();
    logic [5:0] e;
    for (int k = 0; k < 6; k++) e[k] = model_err(k);
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    for (int k = 0; k < 6; k++) begin
      if (a == 6'(8'h10 + k)) m_word[k][23:16] = d;
      if (a == 6'(8'h18 + k)) m_word[k][15:8]  = d;
      if (a == 6'(8'h20 + k)) m_word[k][7:0]   = d;
    end
    if (a == 6'h26) m_en = d[5:0];
    if (a == 6'h27) m_role = d[5:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_slot(int k, logic [23:0] w);
    cfg_write(6'(8'h10 + k), w[23:16]);
    cfg_write(6'(8'h18 + k), w[15:8]);
    cfg_write(6'(8'h20 + k), w[7:0]);
  endtask

  // driver: present one codeword, push expected id for the monitor
  task automatic send_cw(logic [31:0] c, string tag, bit hold = 0);
    @(negedge clk);
    exp_q.push_back(model_id(c));
    tag_q.push_back(tag);
    cw_valid = 1'b1; cw = c;
    if (!hold) begin
      @(negedge clk);
      cw_valid = 1'b0;
    end
  endtask

  task automatic check_errs(string tag);
    logic [5:0] e;
    e = model_errs();
    check(cfg_err == e, tag, cfg_err, e);
  endtask

  // monitor: after every edge that saw a codeword, compare one cycle later
  always @(posedge clk) begin
    if (rst_n && !done) begin
      if (cw_valid) begin
        int e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(match_valid == (e != 0) && match_id == 3'(e), t,
              {match_valid, match_id}, {(e != 0), 3'(e)});
      end else begin
        @(negedge clk);
        check(!match_valid && match_id == 0, "R9 idle", {match_valid, match_id}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) m_word[k] = '0;
    repeat (3) @(negedge clk);
    check(!match_valid && match_id == 0 && cfg_err == 0, "R11 reset",
          {match_valid, match_id, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!match_valid && cfg_err == 0, "R11 after reset", {match_valid, cfg_err}, 0);

    load_slot(0, 24'h02ABCD);
    load_slot(1, 24'h015555);
    load_slot(2, 24'h5A3C96);
    load_slot(3, 24'hAAAA95);   // preamble distance 6
    load_slot(4, 24'hAAAAD5);   // preamble distance 7
    load_slot(5, 24'h02ABCD);   // duplicate of slot 1
    cfg_write(6'h26, 8'h3F);
    cfg_write(6'h27, 8'h1F);    // slots 1,2 role set but ignored
    check_errs("R7 distance 6 flagged, 7 clean");
    check(cfg_err == 6'b001000, "R7 fixed value", cfg_err, 6'b001000);

    send_cw({1'b0, 18'h2ABCD, 13'h1ABC}, "R8 slots 1 and 6 tie");
    send_cw({1'b1, 18'h2ABCD, 13'h1ABC}, "R3 flag bit set");
    send_cw({1'b0, 18'h15555, 13'h0000}, "R4 slot 2 stays address");
    send_cw({1'b0, 18'h15556, 13'h0000}, "R2 address off by one");
    send_cw({24'h5A3C96, 8'h77}, "R5 sync exact");
    send_cw({24'h5A3C96 ^ 24'h000003, 8'h00}, "R5 sync 2 errors");
    send_cw({24'h5A3C96 ^ 24'h000007, 8'h00}, "R5 sync 3 errors");
    send_cw({24'hAAAA95, 8'h00}, "R7 flagged slot 4 excluded");
    check(model_id({24'hAAAA95, 8'h00}) == 5, "R7 model expects 5", 0, 5);
    send_cw({24'hAAAAD5, 8'h3C}, "R5 slot 5 exact");
    send_cw(32'h7CD215D8, "R6 std exact");
    send_cw(32'h7CD215D8 ^ 32'h0000_0003, "R6 std 2 errors");
    send_cw(32'h7CD215D8 ^ 32'h0000_0007, "R6 std 3 errors");

    // back-to-back codewords
    send_cw({1'b0, 18'h15555, 13'h0001}, "R9 burst a", 1);
    send_cw(32'h7CD215D8, "R9 burst b", 1);
    send_cw(32'h1234_5678, "R9 burst c", 1);
    send_cw({24'h5A3C96, 8'h00}, "R9 burst d");

    // writes outside the map are ignored
    cfg_write(6'h16, 8'hFF);
    cfg_write(6'h1E, 8'hFF);
    cfg_write(6'h28, 8'hFF);
    cfg_write(6'h0E, 8'hFF);
    check_errs("R1 stray writes leave flags");
    send_cw({1'b0, 18'h2ABCD, 13'h0000}, "R1 stray writes leave slot 1");
    send_cw({24'hAAAAD5, 8'h00}, "R1 stray writes leave slot 5");

    // push slot 5 across the boundary with one byte
    cfg_write(6'h24, 8'h95);
    check_errs("R7 slot 5 now at distance 6");
    check(cfg_err == 6'b011000, "R7 two flags", cfg_err, 6'b011000);
    send_cw({24'hAAAA95, 8'h00}, "R7 both flagged slots excluded");

    cfg_write(6'h26, 8'h3E);
    send_cw({1'b0, 18'h2ABCD, 13'h0000}, "R10 slot 1 off, slot 6 wins");
    cfg_write(6'h26, 8'h00);
    send_cw({1'b0, 18'h2ABCD, 13'h0000}, "R10 all slots off");
    send_cw({24'h5A3C96, 8'h00}, "R10 sync slot off");
    send_cw(32'h7CD215D8 ^ 32'h8000_0001, "R6 std with slots off");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule